// File: doc/BRIEF.md
# Transparent March FIFO Test Controller

This block wraps the pointer logic of an SRAM-style FIFO that sits in a router input channel and adds periodic on-line testing of the storage array. Most of the time the FIFO serves the router normally. A scheduling counter takes the buffer out of service for a short window at fixed intervals. While the buffer is out of service, a stall output holds off the router's push and pop requests.

During each window the controller tests the single word at the current head slot of the FIFO. It runs a transparent march: read the word into a backup register, write back its complement, read it and compare it with the complement, write back the original, and read it once more and compare it with the backup. A healthy word holds its original value at the end of the window, so queued traffic is not disturbed. Any mismatch on a compare read sets a sticky fault flag. The head slot moves as traffic is popped, so bursts at different times cover different locations.

The storage array is outside the block. The block drives a read address, a write address, write data and a write enable, and takes the read data back combinationally.

Top module: `fifo_march_guard`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `test_mode_o`, `stall_o`, `fault_o` and `mem_we_o` are 0, `empty_o` is 1 and `full_o` is 0.
- R2: After reset, the block stays in normal mode for FIRST_DELAY clock edges and then enters test mode. Each test window lasts WIN clock edges and is followed by PERIOD normal edges. WIN is TEST_WINDOW raised to at least 5.
- R3: In test mode `stall_o` is 1 and `push_i`/`pop_i` have no effect: no push is written, and the queue contents and order seen by later pops are unchanged.
- R4: The word under test is the head slot, whose index is the number of accepted pops modulo DEPTH. In test mode both memory addresses equal that index.
- R5: Let cycle 0 be the first test cycle. In cycle 1 the block writes the bitwise complement of the word read in cycle 0. In cycle 3 it writes the word read in cycle 0. It makes no other test writes.
- R6: With a fault-free array, every word popped equals the word pushed in FIFO order, even across test windows.
- R7: A read in cycle 2 that differs from the complement of the backup, or a read in cycle 4 that differs from the backup, sets `fault_o` from the next cycle on. A stuck-at-1 or a stuck-at-0 bit in the tested word is always caught.
- R8: `fault_o` stays set until `fault_clr_i` is high at a clock edge. If a mismatch occurs at the same edge as a clear, the flag is set.
- R9: In normal mode an accepted push writes `push_data_i` to the tail slot, whose index is the number of accepted pushes modulo DEPTH. A push is accepted only when the FIFO is not full, and a pop only when it is not empty. `full_o` and `empty_o` reflect an occupancy of DEPTH and of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Router push request |
| push_data_i | input | DATA_W | Word to enqueue |
| pop_i | input | 1 | Router pop request |
| pop_data_o | output | DATA_W | Word at the head slot |
| full_o | output | 1 | Occupancy equals DEPTH |
| empty_o | output | 1 | Occupancy is zero |
| stall_o | output | 1 | Router must hold push and pop |
| test_mode_o | output | 1 | Buffer is in a test window |
| fault_o | output | 1 | Sticky fault flag |
| fault_clr_i | input | 1 | Clears the fault flag |
| mem_raddr_o | output | $clog2(DEPTH) | Array read address |
| mem_waddr_o | output | $clog2(DEPTH) | Array write address |
| mem_we_o | output | 1 | Array write enable |
| mem_wdata_o | output | DATA_W | Array write data |
| mem_rdata_i | input | DATA_W | Array read data, combinational |

## Verification
The bench pushes and pops at random during test windows and checks that those requests leave no trace. A design that let them through would corrupt the queue or write the wrong slot in the middle of the march. It checks the exact write pattern in each window and drains the queue at the end. A non-transparent sequence, or one that tests the tail slot, would show up as wrong pop data or a wrong address. It injects a stuck-at-1 on the most significant bit and a stuck-at-0 on the least significant bit at the head slot and checks the cycle in which the flag rises. A clear is placed on the same edge as a mismatch, so a design that gives the clear priority loses the detection.

// File: rtl/fmg_pkg.sv
package fmg_pkg;

    localparam int unsigned MARCH_STEPS = 5;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_LOAD     = 3'd1,
        ST_FLIP     = 3'd2,
        ST_CHK_INV  = 3'd3,
        ST_UNFLIP   = 3'd4,
        ST_CHK_ORIG = 3'd5,
        ST_HOLD     = 3'd6
    } march_step_e;

    typedef struct packed {
        logic load;      // capture read word into backup
        logic wr;        // drive a write this cycle
        logic wr_inv;    // write data is the complement of backup
        logic chk_inv;   // compare read word with complement
        logic chk_orig;  // compare read word with backup
    } march_ctl_t;

    function automatic march_step_e step_after(input march_step_e s);
        case (s)
            ST_LOAD:     return ST_FLIP;
            ST_FLIP:     return ST_CHK_INV;
            ST_CHK_INV:  return ST_UNFLIP;
            ST_UNFLIP:   return ST_CHK_ORIG;
            ST_CHK_ORIG: return ST_HOLD;
            ST_HOLD:     return ST_HOLD;
            default:     return ST_IDLE;
        endcase
    endfunction

    function automatic march_ctl_t step_ctl(input march_step_e s);
        march_ctl_t c;
        c = '0;
        case (s)
            ST_LOAD:     c.load     = 1'b1;
            ST_FLIP:     begin c.wr = 1'b1; c.wr_inv = 1'b1; end
            ST_CHK_INV:  c.chk_inv  = 1'b1;
            ST_UNFLIP:   c.wr       = 1'b1;
            ST_CHK_ORIG: c.chk_orig = 1'b1;
            default:     c = '0;
        endcase
        return c;
    endfunction

    function automatic int unsigned clamp_window(input int unsigned w);
        return (w < MARCH_STEPS) ? MARCH_STEPS : w;
    endfunction

endpackage

// File: rtl/fmg_sched.sv
module fmg_sched #(
    parameter int unsigned FIRST_DELAY = 40,
    parameter int unsigned PERIOD      = 24,
    parameter int unsigned WIN         = 6
) (
    input  logic clk,
    input  logic rst,
    output logic test_mode_o,
    output logic enter_o
);
    localparam int unsigned L1    = (FIRST_DELAY > PERIOD) ? FIRST_DELAY : PERIOD;
    localparam int unsigned LMAX  = (L1 > WIN) ? L1 : WIN;
    localparam int unsigned CNT_W = $clog2(LMAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             first_q;
    logic             mode_q;
    logic             last;

    always_comb begin
        if (mode_q)       limit = CNT_W'(WIN - 1);
        else if (first_q) limit = CNT_W'(FIRST_DELAY - 1);
        else              limit = CNT_W'(PERIOD - 1);
        last = (cnt_q == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            mode_q  <= 1'b0;
            first_q <= 1'b1;
        end else if (last) begin
            cnt_q  <= '0;
            mode_q <= ~mode_q;
            if (!mode_q) first_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign test_mode_o = mode_q;
    assign enter_o     = !mode_q && last;
endmodule

// File: rtl/fmg_ptrs.sv
module fmg_ptrs #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    output logic              push_ok_o,
    output logic [ADDR_W-1:0] wr_ptr_o,
    output logic [ADDR_W-1:0] rd_ptr_o,
    output logic              full_o,
    output logic              empty_o
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  count_q;
    logic [ADDR_W-1:0] wr_q, rd_q, wr_nx, rd_nx;
    logic              pop_ok;

    generate
        if (DEPTH == (1 << ADDR_W)) begin : g_pow2
            assign wr_nx = wr_q + 1'b1;
            assign rd_nx = rd_q + 1'b1;
        end else begin : g_wrap
            assign wr_nx = (wr_q == ADDR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            assign rd_nx = (rd_q == ADDR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
        end
    endgenerate

    assign full_o    = (count_q == CNT_W'(DEPTH));
    assign empty_o   = (count_q == '0);
    assign push_ok_o = push_i && !full_o;
    assign pop_ok    = pop_i && !empty_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
        end else begin
            if (push_ok_o) wr_q <= wr_nx;
            if (pop_ok)    rd_q <= rd_nx;
            case ({push_ok_o, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign wr_ptr_o = wr_q;
    assign rd_ptr_o = rd_q;
endmodule

// File: rtl/fmg_march.sv
module fmg_march
    import fmg_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter_i,
    input  logic              test_mode_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              we_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              fault_o
);
    march_step_e       step_q;
    march_ctl_t        ctl;
    logic [DATA_W-1:0] backup_q;
    logic              fault_q;
    logic              mismatch;

    assign ctl = test_mode_i ? step_ctl(step_q) : '0;

    always_ff @(posedge clk) begin
        if (rst)               step_q <= ST_IDLE;
        else if (enter_i)      step_q <= ST_LOAD;
        else if (!test_mode_i) step_q <= ST_IDLE;
        else                   step_q <= step_after(step_q);
    end

    always_ff @(posedge clk) begin
        if (rst)           backup_q <= '0;
        else if (ctl.load) backup_q <= rdata_i;
    end

    assign we_o    = ctl.wr;
    assign wdata_o = ctl.wr_inv ? ~backup_q : backup_q;

    always_comb begin
        mismatch = 1'b0;
        if (ctl.chk_inv  && (rdata_i != ~backup_q)) mismatch = 1'b1;
        if (ctl.chk_orig && (rdata_i != backup_q))  mismatch = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)           fault_q <= 1'b0;
        else if (mismatch) fault_q <= 1'b1;
        else if (clr_i)    fault_q <= 1'b0;
    end

    assign fault_o = fault_q;
endmodule

// File: rtl/fifo_march_guard.sv
module fifo_march_guard #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned DEPTH       = 8,
    parameter int unsigned FIRST_DELAY = 40,
    parameter int unsigned PERIOD      = 24,
    parameter int unsigned TEST_WINDOW = 6,
    localparam int unsigned ADDR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              stall_o,
    output logic              test_mode_o,
    output logic              fault_o,
    input  logic              fault_clr_i,
    output logic [ADDR_W-1:0] mem_raddr_o,
    output logic [ADDR_W-1:0] mem_waddr_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    localparam int unsigned WIN_LEN = fmg_pkg::clamp_window(TEST_WINDOW);

    logic              tmode, enter;
    logic              push_ok;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic              t_we;
    logic [DATA_W-1:0] t_wdata;

    fmg_sched #(
        .FIRST_DELAY (FIRST_DELAY),
        .PERIOD      (PERIOD),
        .WIN         (WIN_LEN)
    ) sched_i (
        .clk         (clk),
        .rst         (rst),
        .test_mode_o (tmode),
        .enter_o     (enter)
    );

    fmg_ptrs #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) ptrs_i (
        .clk       (clk),
        .rst       (rst),
        .push_i    (push_i && !tmode),
        .pop_i     (pop_i && !tmode),
        .push_ok_o (push_ok),
        .wr_ptr_o  (wr_ptr),
        .rd_ptr_o  (rd_ptr),
        .full_o    (full_o),
        .empty_o   (empty_o)
    );

    fmg_march #(
        .DATA_W (DATA_W)
    ) march_i (
        .clk         (clk),
        .rst         (rst),
        .enter_i     (enter),
        .test_mode_i (tmode),
        .clr_i       (fault_clr_i),
        .rdata_i     (mem_rdata_i),
        .we_o        (t_we),
        .wdata_o     (t_wdata),
        .fault_o     (fault_o)
    );

    assign mem_raddr_o = rd_ptr;
    assign mem_waddr_o = tmode ? rd_ptr  : wr_ptr;
    assign mem_we_o    = tmode ? t_we    : push_ok;
    assign mem_wdata_o = tmode ? t_wdata : push_data_i;
    assign pop_data_o  = mem_rdata_i;
    assign stall_o     = tmode;
    assign test_mode_o = tmode;
endmodule

// File: rtl/fmg_checker.sv
module fmg_checker #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned WIN    = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              test_mode_o,
    input logic              stall_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_waddr_o,
    input logic [ADDR_W-1:0] mem_raddr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              fault_o,
    input logic              fault_clr_i,
    input logic              full_o,
    input logic              empty_o
);
    localparam int unsigned CW = $clog2(WIN + 1) + 1;
    logic [CW-1:0] win_cnt;

    always_ff @(posedge clk) begin
        if (rst)              win_cnt <= '0;
        else if (test_mode_o) win_cnt <= win_cnt + 1'b1;
        else                  win_cnt <= '0;
    end

    p_win_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(test_mode_o) |-> (win_cnt == CW'(WIN)));

    p_win_bound_r2: assert property (@(posedge clk) disable iff (rst)
        test_mode_o |-> (win_cnt < CW'(WIN)));

    p_head_hold_r3: assert property (@(posedge clk) disable iff (rst)
        test_mode_o |=> (test_mode_o -> $stable(mem_raddr_o)));

    p_stall_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(test_mode_o) |-> stall_o);

    p_same_slot_r4: assert property (@(posedge clk) disable iff (rst)
        (test_mode_o && mem_we_o) |-> (mem_waddr_o == mem_raddr_o));

    p_restore_r5: assert property (@(posedge clk) disable iff (rst)
        (test_mode_o && mem_we_o && $past(test_mode_o) && $past(test_mode_o, 2)
         && $past(mem_we_o, 2)) |-> (mem_wdata_o == ~$past(mem_wdata_o, 2)));

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_o && !fault_clr_i) |=> fault_o);

    p_flags_r9: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));
endmodule

bind fifo_march_guard fmg_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .WIN    (WIN_LEN)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .test_mode_o (test_mode_o),
    .stall_o     (stall_o),
    .mem_we_o    (mem_we_o),
    .mem_waddr_o (mem_waddr_o),
    .mem_raddr_o (mem_raddr_o),
    .mem_wdata_o (mem_wdata_o),
    .fault_o     (fault_o),
    .fault_clr_i (fault_clr_i),
    .full_o      (full_o),
    .empty_o     (empty_o)
);

// File: tb/fifo_march_guard_tb_top.sv
module fifo_march_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int FD    = 40;
    localparam int PER   = 24;
    localparam int WIN   = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push = 1'b0, pop = 1'b0, clr = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic [DW-1:0] pop_data, mem_wdata, mem_rdata;
    logic [2:0]    mem_raddr, mem_waddr;
    logic          full, empty, stall, tmode, fault, mem_we;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_march_guard #(
        .DATA_W(DW), .DEPTH(DEPTH), .FIRST_DELAY(FD), .PERIOD(PER), .TEST_WINDOW(WIN)
    ) dut_i (
        .clk(clk), .rst(rst), .push_i(push), .push_data_i(push_data), .pop_i(pop),
        .pop_data_o(pop_data), .full_o(full), .empty_o(empty), .stall_o(stall),
        .test_mode_o(tmode), .fault_o(fault), .fault_clr_i(clr),
        .mem_raddr_o(mem_raddr), .mem_waddr_o(mem_waddr), .mem_we_o(mem_we),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );

    // external array model with optional stuck-at bits on one slot
    logic [DW-1:0] mem [DEPTH];
    logic          fault_on = 1'b0;
    logic [2:0]    faddr = '0;
    logic [DW-1:0] s1 = '0, s0 = '0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (mem_we) begin
            mem[mem_waddr] <= mem_wdata;
        end
    end

    always_comb begin
        mem_rdata = mem[mem_raddr];
        if (fault_on && mem_raddr == faddr) mem_rdata = (mem_rdata | s1) & ~s0;
    end

    int n = 0;
    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    int            vectors = 0, fails = 0;
    logic [DW-1:0] qdat [DEPTH];
    int            qhead = 0, qtail = 0, qcnt = 0;
    logic          exp_fault = 1'b0;
    logic [DW-1:0] bk = '0;
    bit            done = 1'b0;

    function automatic bit mode_at(input int m);
        return (m >= FD) && (((m - FD) % (WIN + PER)) < WIN);
    endfunction

    function automatic int k_at(input int m);
        return (m - FD) % (WIN + PER);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    task automatic cycle(input logic psh, input logic [DW-1:0] pd, input logic pp, input logic cl);
        bit tm;
        int k;
        bit set;
        @(negedge clk);
        push = psh; push_data = pd; pop = pp; clr = cl;
        #1;
        tm  = mode_at(n);
        set = 1'b0;
        chk(tmode == tm, "R2 test_mode", 32'(tmode), 32'(tm));
        chk(stall == tm, "R3 stall", 32'(stall), 32'(tm));
        chk(empty == (qcnt == 0), "R9 empty", 32'(empty), 32'(qcnt == 0));
        chk(full == (qcnt == DEPTH), "R9 full", 32'(full), 32'(qcnt == DEPTH));
        chk(fault == exp_fault, "R7 fault flag", 32'(fault), 32'(exp_fault));
        chk(mem_raddr == 3'(qhead), "R4 head address", 32'(mem_raddr), 32'(qhead));
        if (tm) begin
            k = k_at(n);
            if (k == 0) bk = mem_rdata;
            if (k == 1) begin
                chk(mem_we && mem_waddr == 3'(qhead), "R5 invert write", 32'(mem_we), 32'd1);
                chk(mem_wdata == ~bk, "R5 invert data", 32'(mem_wdata), 32'(~bk));
            end else if (k == 3) begin
                chk(mem_we && mem_waddr == 3'(qhead), "R5 restore write", 32'(mem_we), 32'd1);
                chk(mem_wdata == bk, "R5 restore data", 32'(mem_wdata), 32'(bk));
            end else begin
                chk(!mem_we, "R3 R5 no stray write", 32'(mem_we), 32'd0);
            end
            if (k == 2 && mem_rdata != ~bk) set = 1'b1;
            if (k == 4 && mem_rdata != bk)  set = 1'b1;
        end else begin
            if (psh && qcnt < DEPTH) begin
                chk(mem_we && mem_waddr == 3'(qtail), "R9 push slot", 32'(mem_waddr), 32'(qtail));
                chk(mem_wdata == pd, "R9 push data", 32'(mem_wdata), 32'(pd));
            end else begin
                chk(!mem_we, "R9 no write", 32'(mem_we), 32'd0);
            end
            if (pp && qcnt > 0) begin
                chk(pop_data == qdat[qhead], "R6 pop data", 32'(pop_data), 32'(qdat[qhead]));
            end
            begin
                bit pu, po;
                pu = psh && qcnt < DEPTH;
                po = pp && qcnt > 0;
                if (pu) begin qdat[qtail] = pd; qtail = (qtail + 1) % DEPTH; end
                if (po) qhead = (qhead + 1) % DEPTH;
                qcnt = qcnt + (pu ? 1 : 0) - (po ? 1 : 0);
            end
        end
        if (set)     exp_fault = 1'b1;
        else if (cl) exp_fault = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(tmode == 1'b0, "R1 test_mode", 32'(tmode), 32'd0);
        chk(stall == 1'b0, "R1 stall", 32'(stall), 32'd0);
        chk(fault == 1'b0, "R1 fault", 32'(fault), 32'd0);
        chk(empty == 1'b1 && full == 1'b0, "R1 flags", {30'd0, full, empty}, 32'd1);
        chk(mem_we == 1'b0, "R1 write enable", 32'(mem_we), 32'd0);

        // random traffic, requests also driven inside test windows (R3)
        for (int i = 0; i < 150; i++)
            cycle(($urandom % 4) != 0, DW'($urandom), ($urandom % 4) == 0, 1'b0);
        for (int i = 0; i < 150; i++)
            cycle(($urandom % 4) == 0, DW'($urandom), ($urandom % 4) != 0, 1'b0);
        for (int i = 0; i < 500; i++)
            cycle(($urandom % 2) == 0, DW'($urandom), ($urandom % 2) == 0, 1'b0);
        for (int i = 0; i < 60; i++)
            cycle(1'b1, DW'($urandom), 1'b0, 1'b0);
        while (qcnt > 0) cycle(1'b0, '0, 1'b1, 1'b0);
        cycle(1'b0, '0, 1'b0, 1'b0);
        chk(empty == 1'b1, "R6 drained", 32'(empty), 32'd1);
        chk(fault == 1'b0, "R6 no false fault", 32'(fault), 32'd0);

        // stuck-at-1 on MSB at the head slot
        fault_on = 1'b1; faddr = 3'(qhead); s1 = 8'h80; s0 = 8'h00;
        for (int i = 0; i < 2 * (WIN + PER); i++) cycle(1'b0, '0, 1'b0, 1'b0);
        chk(fault == 1'b1, "R7 stuck-at-1 caught", 32'(fault), 32'd1);
        for (int i = 0; i < WIN + PER; i++) cycle(1'b0, '0, 1'b0, 1'b0);
        chk(fault == 1'b1, "R8 sticky", 32'(fault), 32'd1);

        // clear outside a window, repair the cell
        while (mode_at(n + 1)) cycle(1'b0, '0, 1'b0, 1'b0);
        cycle(1'b0, '0, 1'b0, 1'b1);
        fault_on = 1'b0;
        cycle(1'b0, '0, 1'b0, 1'b0);
        chk(fault == 1'b0, "R8 cleared", 32'(fault), 32'd0);
        for (int i = 0; i < 2 * (WIN + PER); i++) cycle(1'b0, '0, 1'b0, 1'b0);
        chk(fault == 1'b0, "R8 stays clear", 32'(fault), 32'd0);

        // stuck-at-0 on LSB, clear asserted on the mismatch edge
        fault_on = 1'b1; s1 = 8'h00; s0 = 8'h01;
        for (int i = 0; i < 2 * (WIN + PER); i++)
            cycle(1'b0, '0, 1'b0, mode_at(n + 1) && k_at(n + 1) == 2);
        chk(fault == 1'b1, "R8 set beats clear, R7 stuck-at-0", 32'(fault), 32'd1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule